// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This controller sits beside the switch that joins an upstream I2C segment to a downstream one. It watches the synchronized downstream SDA and SCL levels. If either line stays low for longer than a set limit, it drops an active-low fault flag. What happens next depends on a strap pin. In fault-only mode the flag is the only reaction, and the two segments stay joined. In recovery mode the controller does four things in order:

1. It opens the connection enable.
2. It waits for a guard interval.
3. It toggles downstream SCL through open-drain pull-down requests. The burst is capped at a set number of pulses.
4. It finishes with a STOP condition.

Afterwards it rejoins the segments at a safe point. That point is either a STOP condition (SDA rising while SCL is high) or a bus-idle interval with both lines high.

All times are parameters given in microseconds or hertz, and they are converted to cycles of the system clock. The outputs only request pull-downs; the block never drives a line high. A power-good input holds the block in its disconnected, released state. The stuck-low timers count only after power-good is high, so a bus that is already stuck at power-up is reported one full timeout after power-good rises. That bus then goes through the same recovery sequence.

The block has no streaming data path. Every pin is a plain level signal, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_unstick`

## Requirements
- R1: After reset, with power-good high, `conn_en` is 0, `fault_n` is 1 and both pull-down requests are 0. `conn_en` rises only after both lines have been high for IDLE_US.
- R2: `fault_n` falls once a downstream line has been low continuously for STUCK_US. A line that returns high before then restarts its own timer, and no fault is raised.
- R3: `fault_n` returns to 1 as soon as the line that was stuck is seen high again.
- R4: With `disc_en` = 0, a timeout lowers `fault_n` only. `conn_en` stays 1, and `scl_pd` and `sda_pd` stay 0.
- R5: With `disc_en` = 1, a timeout clears `conn_en` one cycle after `fault_n` falls. A pull-down request is never active while `conn_en` is 1.
- R6: The first SCL pull-down of a burst begins GUARD_US after `conn_en` falls.
- R7: The burst holds `scl_pd` = 1 for a half period and then 0 for a half period, where a half period is CLK_HZ/(2*SCL_HZ) cycles. There are at most PULSES such pulses.
- R8: If SDA is seen high at the end of a released-SCL half period, the burst ends there and the STOP sequence follows.
- R9: The STOP sequence runs in this order, with each step lasting a half period: SCL pulled alone; SCL and SDA pulled together; SDA pulled alone; then both released.
- R10: After recovery, or while disconnected, the connection is re-enabled when SDA rises with SCL high, or after IDLE_US with both lines high.
- R11: While power-good is low, every output is released, `conn_en` is 0 and the timers are cleared. A line stuck at power-up raises the fault STUCK_US after power-good rises, and recovery follows. The connection is not enabled first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | High when supply is above the lockout threshold |
| disc_en | input | 1 | Strap: 1 = full recovery, 0 = fault flag only |
| sda_in | input | 1 | Downstream SDA level (asynchronous) |
| scl_in | input | 1 | Downstream SCL level (asynchronous) |
| fault_n | output | 1 | Active-low stuck-bus flag |
| conn_en | output | 1 | Enable for the upstream/downstream connection switch |
| sda_pd | output | 1 | Request to pull downstream SDA low |
| scl_pd | output | 1 | Request to pull downstream SCL low |

## Verification
The controller is tried with several stuck-bus patterns:

- A line that drops low twice, each time just short of the timeout. This separates a restarting timer from one that accumulates.
- A stuck SCL with the strap low. This shows the flag working on its own, with no recovery.
- A stuck SDA that lets go during the third pulse. This exercises the early exit from the burst.
- A slave that holds SDA through all sixteen pulses. This shows the pulse cap and the full STOP ordering.
- A bus that is already stuck when power-good rises.

A scoreboard compares every change of the four outputs against the expected order. Cycle counts check the timeout, the guard, the half period and the idle interval.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_LINK,
    ST_GUARD,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_STOP_A,
    ST_STOP_B,
    ST_STOP_C
  } unstick_st_e;

  function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned us);
    longint unsigned c;
    c = (clk_hz * us) / 64'd1_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/i2c_unstick_sync.sv
module i2c_unstick_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Idle bus level is high, so the chain resets to ones.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/i2c_unstick_lowtimer.sv
module i2c_unstick_lowtimer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic line_hi,
  output logic expired
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr || line_hi)   cnt <= '0;
    else if (cnt != LIM)       cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/i2c_unstick_fsm.sv
module i2c_unstick_fsm
  import i2c_unstick_pkg::*;
#(
  parameter int unsigned GUARD_CYC = 40,
  parameter int unsigned HALF_CYC  = 58,
  parameter int unsigned IDLE_CYC  = 100,
  parameter int unsigned PULSES    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic disc_en,
  input  logic sda_s,
  input  logic scl_s,
  input  logic expired,
  output logic conn_en,
  output logic scl_pd,
  output logic sda_pd
);
  localparam int unsigned TMAX = max3(GUARD_CYC, HALF_CYC, IDLE_CYC);
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned PW   = $clog2(PULSES + 1);
  localparam logic [TW-1:0] GUARD_LAST = TW'(GUARD_CYC - 1);
  localparam logic [TW-1:0] HALF_LAST  = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] IDLE_LAST  = TW'(IDLE_CYC - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSES - 1);

  unstick_st_e   state;
  logic [TW-1:0] tmr;
  logic [PW-1:0] pcnt;
  logic          sda_q, exp_q;
  logic          exp_rise, stop_seen, half_done;

  assign exp_rise  = expired & ~exp_q;
  assign stop_seen = sda_s & ~sda_q & scl_s;
  assign half_done = (tmr == HALF_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAIT;
      tmr   <= '0;
      pcnt  <= '0;
      sda_q <= 1'b1;
      exp_q <= 1'b0;
    end else begin
      sda_q <= sda_s;
      exp_q <= expired;
      if (!pwr_good) begin
        state <= ST_WAIT;
        tmr   <= '0;
        pcnt  <= '0;
      end else begin
        unique case (state)
          ST_WAIT: begin
            if (exp_rise && disc_en) begin
              state <= ST_GUARD;
              tmr   <= '0;
            end else if (stop_seen) begin
              state <= ST_LINK;
              tmr   <= '0;
            end else if (sda_s && scl_s) begin
              if (tmr == IDLE_LAST) begin
                state <= ST_LINK;
                tmr   <= '0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end else begin
              tmr <= '0;
            end
          end
          ST_LINK: begin
            if (exp_rise && disc_en) begin
              state <= ST_GUARD;
              tmr   <= '0;
            end
          end
          ST_GUARD: begin
            if (tmr == GUARD_LAST) begin
              state <= ST_CLK_LO;
              tmr   <= '0;
              pcnt  <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
          ST_CLK_LO: begin
            if (half_done) begin
              state <= ST_CLK_HI;
              tmr   <= '0;
            end else tmr <= tmr + 1'b1;
          end
          ST_CLK_HI: begin
            if (half_done) begin
              tmr  <= '0;
              pcnt <= pcnt + 1'b1;
              if (sda_s || pcnt == PULSE_LAST) state <= ST_STOP_A;
              else                             state <= ST_CLK_LO;
            end else tmr <= tmr + 1'b1;
          end
          ST_STOP_A: begin
            if (half_done) begin
              state <= ST_STOP_B;
              tmr   <= '0;
            end else tmr <= tmr + 1'b1;
          end
          ST_STOP_B: begin
            if (half_done) begin
              state <= ST_STOP_C;
              tmr   <= '0;
            end else tmr <= tmr + 1'b1;
          end
          ST_STOP_C: begin
            if (half_done) begin
              state <= ST_WAIT;
              tmr   <= '0;
            end else tmr <= tmr + 1'b1;
          end
          default: begin
            state <= ST_WAIT;
            tmr   <= '0;
          end
        endcase
      end
    end
  end

  assign conn_en = (state == ST_LINK);
  assign scl_pd  = (state == ST_CLK_LO) || (state == ST_STOP_A) || (state == ST_STOP_B);
  assign sda_pd  = (state == ST_STOP_B) || (state == ST_STOP_C);
endmodule

// File: rtl/i2c_unstick.sv
module i2c_unstick
  import i2c_unstick_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned STUCK_US    = 30_000,
  parameter int unsigned GUARD_US    = 40,
  parameter int unsigned SCL_HZ      = 8_500,
  parameter int unsigned IDLE_US     = 100,
  parameter int unsigned PULSES      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic disc_en,
  input  logic sda_in,
  input  logic scl_in,
  output logic fault_n,
  output logic conn_en,
  output logic sda_pd,
  output logic scl_pd
);
  localparam int unsigned STUCK_CYC = us_to_cycles(CLK_HZ, STUCK_US);
  localparam int unsigned GUARD_CYC = us_to_cycles(CLK_HZ, GUARD_US);
  localparam int unsigned IDLE_CYC  = us_to_cycles(CLK_HZ, IDLE_US);
  localparam int unsigned HALF_RAW  = CLK_HZ / (2 * SCL_HZ);
  localparam int unsigned HALF_CYC  = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned NLINE     = 2;   // index 0 = SDA, 1 = SCL

  logic [NLINE-1:0] line_raw, line_s, line_exp;

  assign line_raw = {scl_in, sda_in};

  i2c_unstick_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(line_raw), .q(line_s)
  );

  for (genvar i = 0; i < NLINE; i++) begin : g_tmr
    i2c_unstick_lowtimer #(.LIMIT(STUCK_CYC)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(~pwr_good),
      .line_hi(line_s[i]), .expired(line_exp[i])
    );
  end

  i2c_unstick_fsm #(
    .GUARD_CYC(GUARD_CYC), .HALF_CYC(HALF_CYC),
    .IDLE_CYC(IDLE_CYC), .PULSES(PULSES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .disc_en(disc_en),
    .sda_s(line_s[0]), .scl_s(line_s[1]), .expired(|line_exp),
    .conn_en(conn_en), .scl_pd(scl_pd), .sda_pd(sda_pd)
  );

  assign fault_n = ~|line_exp;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
  parameter int unsigned STUCK_CYC = 100
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic sda_in,
  input logic scl_in,
  input logic fault_n,
  input logic conn_en,
  input logic sda_pd,
  input logic scl_pd
);
  int unsigned sda_run, scl_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_run <= 0;
      scl_run <= 0;
    end else begin
      if (sda_in)                     sda_run <= 0;
      else if (sda_run <= STUCK_CYC)  sda_run <= sda_run + 1;
      if (scl_in)                     scl_run <= 0;
      else if (scl_run <= STUCK_CYC)  scl_run <= scl_run + 1;
    end
  end

  assert_fault_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> (sda_run >= STUCK_CYC || scl_run >= STUCK_CYC));

  assert_no_pull_when_linked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pd || sda_pd) |-> !conn_en);

  assert_sda_pull_under_scl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pd) |-> scl_pd);

  assert_sda_release_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pd) |-> !scl_pd);

  assert_relink_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_en) |-> (fault_n && !scl_pd && !sda_pd));

  assert_power_low_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!conn_en && !scl_pd && !sda_pd && fault_n));
endmodule

bind i2c_unstick i2c_unstick_chk #(.STUCK_CYC(STUCK_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sda_in(sda_in), .scl_in(scl_in),
  .fault_n(fault_n), .conn_en(conn_en), .sda_pd(sda_pd), .scl_pd(scl_pd)
);

// File: tb/i2c_unstick_tb.sv
`timescale 1ns/1ps
module i2c_unstick_tb;
  // Scaled timing: design sees 1 cycle per microsecond.
  localparam int CLK_HZ = 1_000_000;
  localparam int STUCK  = 2000;
  localparam int GUARD  = 40;
  localparam int HALF   = CLK_HZ / (2 * 8500);   // 58
  localparam int IDLE   = 100;
  localparam int NPUL   = 16;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1, disc_en = 1'b1;
  logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic sda_line, scl_line, fault_n, conn_en, sda_pd, scl_pd;

  always #5 clk = ~clk;

  assign sda_line = !(sda_pd || ext_sda_low);
  assign scl_line = !(scl_pd || ext_scl_low);

  i2c_unstick #(.CLK_HZ(CLK_HZ), .STUCK_US(STUCK), .GUARD_US(GUARD),
                .SCL_HZ(8500), .IDLE_US(IDLE), .PULSES(NPUL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .disc_en(disc_en),
    .sda_in(sda_line), .scl_in(scl_line),
    .fault_n(fault_n), .conn_en(conn_en), .sda_pd(sda_pd), .scl_pd(scl_pd)
  );

  // Observed vector: {fault_n, conn_en, scl_pd, sda_pd}
  logic [3:0] vec;
  assign vec = {fault_n, conn_en, scl_pd, sda_pd};

  typedef struct { logic [3:0] v; string tag; } exp_t;
  exp_t exq[$];

  int n_chk = 0, n_fail = 0;
  bit mon_on = 0, done = 0;
  logic [3:0] last_vec;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic push_pulses(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      push(4'b0010, tag);
      push(4'b0000, tag);
    end
  endtask

  // Monitor: every change of the output vector must match the next expected item.
  always @(negedge clk) begin
    if (mon_on && vec !== last_vec) begin
      if (exq.size() == 0) begin
        chk(1'b0, "unexpected output change", int'(vec), int'(last_vec));
      end else begin
        exp_t e;
        e = exq.pop_front();
        chk(vec === e.v, e.tag, int'(vec), int'(e.v));
      end
      last_vec = vec;
    end
  end

  task automatic drain(input string tag);
    int n;
    n = 0;
    while (exq.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(exq.size() == 0, tag, exq.size(), 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, rises, hi_w;
    bit prev_scl, first_measured;

    // ---- R1: reset state and idle-based first connection
    repeat (5) @(negedge clk);
    chk(vec == 4'b1000, "R1 reset outputs", int'(vec), 8);
    rst_n = 1'b1;
    last_vec = vec;
    mon_on = 1;
    push(4'b1100, "R1 link after idle");
    n = 0;
    while (!conn_en && n < 1000) begin
      @(negedge clk);
      n++;
      if (n == IDLE / 2) chk(conn_en == 1'b0, "R1 no link before idle", conn_en, 0);
    end
    chk(n >= IDLE && n <= IDLE + 2, "R1 idle interval", n, IDLE);
    drain("R1 sequence");

    // ---- R2: two low stretches, each shorter than the timeout
    ext_sda_low = 1'b1;
    repeat (STUCK - 20) @(negedge clk);
    ext_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (STUCK - 20) @(negedge clk);
    ext_sda_low = 1'b0;
    repeat (10) @(negedge clk);
    chk(vec == 4'b1100, "R2 short lows raise no fault", int'(vec), 12);

    // ---- R4 / R2 / R3: fault-only mode with SCL stuck
    disc_en = 1'b0;
    push(4'b0100, "R4 fault only, still linked");
    push(4'b1100, "R3 fault clears on release");
    ext_scl_low = 1'b1;
    n = 0;
    while (fault_n && n < STUCK + 50) begin
      @(negedge clk);
      n++;
    end
    chk(n >= STUCK + 1 && n <= STUCK + 3, "R2 timeout length", n, STUCK + 2);
    repeat (300) @(negedge clk);
    chk(conn_en && !scl_pd && !sda_pd, "R4 no disconnect or pulls", int'(vec), 4);
    ext_scl_low = 1'b0;
    drain("R3 R4 sequence");

    // ---- R5 R6 R8 R9 R10: recovery, slave lets go during third pulse
    disc_en = 1'b1;
    push(4'b0100, "R2 fault");
    push(4'b0000, "R5 disconnect");
    push_pulses(2, "R7 pulse");
    push(4'b0010, "R7 third pulse low");
    push(4'b1010, "R3 fault clears mid pulse");
    push(4'b1000, "R7 third pulse high");
    push(4'b1010, "R8 early exit to stop, R9 step scl");
    push(4'b1011, "R9 step both");
    push(4'b1001, "R9 step sda");
    push(4'b1000, "R9 release");
    push(4'b1100, "R10 relink on stop");
    ext_sda_low = 1'b1;
    while (conn_en) @(negedge clk);
    n = 0;
    while (!scl_pd && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(n >= GUARD && n <= GUARD + 1, "R6 guard interval", n, GUARD);
    @(posedge scl_pd);
    @(posedge scl_pd);
    @(negedge clk);
    ext_sda_low = 1'b0;
    drain("R8 R9 R10 sequence");

    // ---- R7 R9: slave holds SDA through the whole burst
    push(4'b0100, "R2 fault");
    push(4'b0000, "R5 disconnect");
    push_pulses(NPUL, "R7 full burst");
    push(4'b0010, "R9 step scl");
    push(4'b0011, "R9 step both");
    push(4'b0001, "R9 step sda");
    push(4'b0000, "R9 release sda");
    push(4'b1100, "R10 relink on rising sda");
    ext_sda_low = 1'b1;
    while (conn_en) @(negedge clk);
    rises = 0; hi_w = 0; prev_scl = 0; first_measured = 0;
    while (!sda_pd) begin
      @(negedge clk);
      if (scl_pd && !prev_scl) rises++;
      if (rises == 1 && scl_pd) hi_w++;
      prev_scl = scl_pd;
    end
    chk(hi_w == HALF, "R7 half period", hi_w, HALF);
    chk(rises == NPUL + 1, "R7 pulse cap", rises - 1, NPUL);
    @(negedge clk);
    ext_sda_low = 1'b0;
    drain("R7 R9 sequence");

    // ---- R11: power-good low, bus stuck at power-up
    push(4'b1000, "R11 link drops on power loss");
    pwr_good = 1'b0;
    repeat (5) @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (STUCK + 50) @(negedge clk);
    chk(vec == 4'b1000, "R11 quiet while power low", int'(vec), 8);
    push(4'b0000, "R11 fault after power good");
    push_pulses(1, "R11 pulse");
    push(4'b0010, "R11 second pulse low");
    push(4'b1010, "R3 fault clears");
    push(4'b1000, "R11 second pulse high");
    push(4'b1010, "R9 step scl");
    push(4'b1011, "R9 step both");
    push(4'b1001, "R9 step sda");
    push(4'b1000, "R9 release");
    push(4'b1100, "R10 relink");
    pwr_good = 1'b1;
    n = 0;
    while (fault_n && n < STUCK + 50) begin
      @(negedge clk);
      n++;
    end
    chk(n >= STUCK - 1 && n <= STUCK + 3, "R11 timeout from power good", n, STUCK);
    @(posedge scl_pd);
    @(posedge scl_pd);
    @(negedge clk);
    ext_sda_low = 1'b0;
    drain("R11 sequence");

    finish_run();
  end
endmodule